// File: doc/BRIEF.md
# Multistage Audio Decimation Filter

This block takes a stream of narrow signed samples from a sigma-delta modulator running at 64 times the audio sample rate. It returns one 24-bit signed sample for each 64 accepted inputs. The chain has three parts. A fourth-order comb-integrator decimator first lowers the rate by 8. Three half-band FIR stages follow, and each one halves the rate again. A first-order DC-blocking high-pass comes last, and a control input can switch it out.

One instance handles one channel, so a stereo converter uses two instances side by side. The input strobe may be low for any number of cycles. Samples are counted only when it is high, and the output strobe is a single-cycle pulse. The reset input is asynchronous and active low. Inside the block, its release is synchronised to the clock.

Top module: `audio_decim_chain`

## Requirements
- R1: While reset is asserted, and after it is released until the first result, `out_valid` is 0 and `out_sample` is 0.
- R2: `out_valid` pulses exactly once for every 64 samples accepted with `in_valid` high. Cycles with `in_valid` low change nothing, and `out_sample` holds its value between pulses.
- R3: Count the clock edge that accepts the 64th sample of a group as edge 1. `out_valid` is high for exactly one cycle, after edge 5.
- R4: The first stage equals four cascaded 8-sample running sums of the accepted inputs, taken on every 8th accepted input (8th, 16th, …). This gives a DC gain of 4096. Its result is shifted left by `OUT_W-IN_W-12` bits before the half-band stages.
- R5: Each half-band stage uses w0 as its newest input and w6 as the input six before it. On its 2nd, 4th, … input after reset it produces floor((−w0 + 9·w2 + 16·w3 + 9·w4 − w6)/32). Samples before reset count as zero.
- R6: With `hp_bypass` at 0, the high-pass computes y = x − x_prev + y_prev − L. L is y_prev divided by 2^`HP_SHIFT` (default 10), rounded away from zero.
- R7: Every output is clamped to the range [−8388608, 8388607]. The clamped value is the one kept as y_prev.
- R8: With `hp_bypass` at 1, the output is the clamped third half-band result. The high-pass state still updates as in R6.
- R9: A constant input d makes the output settle to exactly 0 with the high-pass active. In bypass, the settled output is d·2^(`OUT_W`−`IN_W`), which is 1048576·d at the default widths.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | IN_W | Signed modulator sample |
| hp_bypass | input | 1 | 1 selects the output ahead of the high-pass |
| out_valid | output | 1 | Output sample strobe, one cycle |
| out_sample | output | OUT_W | Signed decimated sample |

## Verification
Every result is due a fixed number of cycles after the edge that accepts the 64th sample of its group. The comb stage adds one register, each half-band adds one, and the high-pass adds one. The output therefore appears after the fifth edge, counting the accepting edge as the first.

The bench sends each input it drives into its own reference model at the moment it drives that input. At each 64th input it records the cycle in which the output is due. On every output pulse, it compares both the value and the arrival cycle with the oldest record. Control changes happen only after the pipeline has drained.

// File: rtl/audio_decim_pkg.sv
package audio_decim_pkg;

  // Clamp a wide signed value into a signed range of `width` bits.
  function automatic logic signed [63:0] clamp_signed(input logic signed [63:0] v,
                                                      input int unsigned width);
    logic signed [63:0] hi;
    logic signed [63:0] lo;
    hi = (64'sd1 <<< (width - 1)) - 64'sd1;
    lo = -(64'sd1 <<< (width - 1));
    if (v > hi)      clamp_signed = hi;
    else if (v < lo) clamp_signed = lo;
    else             clamp_signed = v;
  endfunction

endpackage

// File: rtl/cic_decim.sv
module cic_decim #(
  parameter int IN_W      = 4,
  parameter int GROWTH    = 12,
  parameter int ORDER     = 4,
  parameter int RATE_LOG2 = 3
) (
  input  logic                          clk,
  input  logic                          rst_ni,
  input  logic                          in_valid,
  input  logic signed [IN_W-1:0]        in_data,
  output logic                          out_valid,
  output logic signed [IN_W+GROWTH-1:0] out_data
);
  localparam int W = IN_W + GROWTH;

  logic signed [W-1:0] integ_q [ORDER];
  logic signed [W-1:0] integ_d [ORDER];
  logic signed [W-1:0] dly_q   [ORDER];
  logic signed [W-1:0] dly_d   [ORDER];
  logic signed [W-1:0] comb_res;
  logic [RATE_LOG2-1:0] phase_q, phase_d;
  logic                 decim_en;
  logic signed [W-1:0]  out_q, out_d;
  logic                 vld_q;

  assign decim_en = in_valid && (phase_q == {RATE_LOG2{1'b1}});

  // Integrator chain at the input rate
  always_comb begin
    logic signed [W-1:0] link;
    link = W'(in_data);
    for (int k = 0; k < ORDER; k++) begin
      integ_d[k] = integ_q[k] + link;
      link       = integ_d[k];
    end
  end

  // Comb chain at the decimated rate, differential delay one
  always_comb begin
    logic signed [W-1:0] link;
    link = integ_d[ORDER-1];
    for (int k = 0; k < ORDER; k++) begin
      dly_d[k] = link;
      link     = link - dly_q[k];
    end
    comb_res = link;
  end

  always_comb begin
    phase_d = in_valid ? phase_q + 1'b1 : phase_q;
    out_d   = decim_en ? comb_res : out_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < ORDER; k++) begin
        integ_q[k] <= '0;
        dly_q[k]   <= '0;
      end
      phase_q <= '0;
      out_q   <= '0;
      vld_q   <= 1'b0;
    end else begin
      if (in_valid) begin
        for (int k = 0; k < ORDER; k++) integ_q[k] <= integ_d[k];
      end
      if (decim_en) begin
        for (int k = 0; k < ORDER; k++) dly_q[k] <= dly_d[k];
      end
      phase_q <= phase_d;
      out_q   <= out_d;
      vld_q   <= decim_en;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = out_q;
endmodule

// File: rtl/halfband_decim.sv
module halfband_decim #(
  parameter int W = 26
) (
  input  logic                clk,
  input  logic                rst_ni,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_data,
  output logic                out_valid,
  output logic signed [W-1:0] out_data
);
  localparam int TAPS  = 7;
  localparam int HIST  = TAPS - 1;
  localparam int SCALE = 5;            // coefficient sum is 32
  localparam int SW    = W + SCALE + 1;

  logic signed [W-1:0]  hist_q [HIST];
  logic                 phase_q, phase_d;
  logic signed [SW-1:0] acc;
  logic signed [W-1:0]  out_q, out_d;
  logic                 vld_q, emit;

  assign emit = in_valid && phase_q;

  // taps -1, 0, 9, 16, 9, 0, -1 : zero taps skipped
  always_comb begin
    logic signed [SW-1:0] t0, t2, t3, t4, t6;
    t0  = SW'(in_data);
    t2  = SW'(hist_q[1]);
    t3  = SW'(hist_q[2]);
    t4  = SW'(hist_q[3]);
    t6  = SW'(hist_q[5]);
    acc = (t2 <<< 3) + t2 + (t3 <<< 4) + (t4 <<< 3) + t4 - t0 - t6;
  end

  always_comb begin
    phase_d = in_valid ? ~phase_q : phase_q;
    out_d   = emit ? W'(acc >>> SCALE) : out_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < HIST; k++) hist_q[k] <= '0;
      phase_q <= 1'b0;
      out_q   <= '0;
      vld_q   <= 1'b0;
    end else begin
      if (in_valid) begin
        hist_q[0] <= in_data;
        for (int k = 1; k < HIST; k++) hist_q[k] <= hist_q[k-1];
      end
      phase_q <= phase_d;
      out_q   <= out_d;
      vld_q   <= emit;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = out_q;
endmodule

// File: rtl/dc_block_hp.sv
module dc_block_hp
  import audio_decim_pkg::*;
#(
  parameter int IN_W  = 26,
  parameter int OUT_W = 24,
  parameter int SHIFT = 10
) (
  input  logic                    clk,
  input  logic                    rst_ni,
  input  logic                    bypass,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_data,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_data
);
  localparam int AW = IN_W + 3;

  logic signed [IN_W-1:0]  xprev_q;
  logic signed [OUT_W-1:0] yprev_q, yprev_d;
  logic signed [OUT_W-1:0] out_q, out_d;
  logic                    vld_q;
  logic signed [AW-1:0]    leak, raw;
  logic signed [OUT_W-1:0] thru;

  always_comb begin
    logic signed [AW-1:0] yw;
    yw = AW'(yprev_q);
    // leak rounded away from zero so positive residue also decays to 0
    if (yw > 0) leak = (yw + AW'((1 << SHIFT) - 1)) >>> SHIFT;
    else        leak = yw >>> SHIFT;
    raw     = AW'(in_data) - AW'(xprev_q) + yw - leak;
    yprev_d = OUT_W'(clamp_signed(64'(raw), OUT_W));
    thru    = OUT_W'(clamp_signed(64'(in_data), OUT_W));
    if (!in_valid)   out_d = out_q;
    else if (bypass) out_d = thru;
    else             out_d = yprev_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      xprev_q <= '0;
      yprev_q <= '0;
      out_q   <= '0;
      vld_q   <= 1'b0;
    end else begin
      if (in_valid) begin
        xprev_q <= in_data;
        yprev_q <= yprev_d;
      end
      out_q <= out_d;
      vld_q <= in_valid;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = out_q;
endmodule

// File: rtl/audio_decim_chain.sv
module audio_decim_chain #(
  parameter int IN_W     = 4,
  parameter int OUT_W    = 24,
  parameter int GROWTH   = 12,
  parameter int NUM_HB   = 3,
  parameter int HB_GUARD = 2,
  parameter int HP_SHIFT = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_sample,
  input  logic                    hp_bypass,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_sample
);
  localparam int CIC_W = IN_W + GROWTH;
  localparam int ALIGN = OUT_W - CIC_W;
  localparam int HB_W  = OUT_W + HB_GUARD;

  logic rst_meta_q, rst_sync_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic                    cic_valid;
  logic signed [CIC_W-1:0] cic_data;

  cic_decim #(
    .IN_W(IN_W), .GROWTH(GROWTH), .ORDER(4), .RATE_LOG2(3)
  ) u_cic (
    .clk(clk), .rst_ni(rst_sync_q), .in_valid(in_valid), .in_data(in_sample),
    .out_valid(cic_valid), .out_data(cic_data)
  );

  logic                   hb_vld [NUM_HB+1];
  logic signed [HB_W-1:0] hb_dat [NUM_HB+1];

  assign hb_vld[0] = cic_valid;
  assign hb_dat[0] = HB_W'(signed'({cic_data, {ALIGN{1'b0}}}));

  for (genvar s = 0; s < NUM_HB; s++) begin : g_hb
    halfband_decim #(.W(HB_W)) u_hb (
      .clk(clk), .rst_ni(rst_sync_q),
      .in_valid(hb_vld[s]), .in_data(hb_dat[s]),
      .out_valid(hb_vld[s+1]), .out_data(hb_dat[s+1])
    );
  end

  dc_block_hp #(.IN_W(HB_W), .OUT_W(OUT_W), .SHIFT(HP_SHIFT)) u_hp (
    .clk(clk), .rst_ni(rst_sync_q), .bypass(hp_bypass),
    .in_valid(hb_vld[NUM_HB]), .in_data(hb_dat[NUM_HB]),
    .out_valid(out_valid), .out_data(out_sample)
  );
endmodule

// File: rtl/audio_decim_chain_chk.sv
module audio_decim_chain_chk #(
  parameter int OUT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_sample,
  input logic             cic_valid
);
  logic [7:0] gap_q;
  logic       seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      if (out_valid)            gap_q <= 8'd1;
      else if (gap_q != 8'hFF)  gap_q <= gap_q + 8'd1;
      if (out_valid) seen_q <= 1'b1;
    end
  end

  // R1: outputs cleared while reset is held
  p_reset_clear_r1: assert property (@(posedge clk) !rst_n |-> (!out_valid && out_sample == '0));

  // R2: successive results are at least 64 cycles apart
  p_rate_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && seen_q) |-> gap_q >= 8'd64);

  // R2: sample held between strobes
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_sample));

  // R3: single-cycle strobe
  p_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R4: first stage emits isolated pulses
  p_cic_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cic_valid |=> !cic_valid);
endmodule

bind audio_decim_chain audio_decim_chain_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid),
  .out_sample(out_sample), .cic_valid(cic_valid)
);

// File: tb/tb_audio_decim_chain.sv
module tb_audio_decim_chain;
  localparam int CLK_PERIOD = 10;
  localparam int IN_W  = 4;
  localparam int OUT_W = 24;
  localparam int SHIFT = 4;      // shortened high-pass time constant for run length
  localparam int SCALE = OUT_W - IN_W - 12;
  localparam longint MAXV = (64'sd1 <<< (OUT_W - 1)) - 1;
  localparam longint MINV = -(64'sd1 <<< (OUT_W - 1));

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic signed [IN_W-1:0] in_sample;
  logic hp_bypass;
  logic out_valid;
  logic signed [OUT_W-1:0] out_sample;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_decim_chain #(.IN_W(IN_W), .OUT_W(OUT_W), .HP_SHIFT(SHIFT)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .hp_bypass(hp_bypass), .out_valid(out_valid), .out_sample(out_sample)
  );

  int checks = 0, fails = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // reference model state
  longint coef [29];
  longint hist [29];
  longint hbw [3][7];
  bit     hbph [3];
  longint hx1, hy1;
  longint accepted = 0, outs = 0;
  longint exp_val [$];
  longint exp_cyc [$];
  longint last_out;
  bit     saw_max;

  function automatic longint sat(longint v);
    if (v > MAXV) return MAXV;
    if (v < MINV) return MINV;
    return v;
  endfunction

  task automatic check(bit ok, string req, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < 29; k++) hist[k] = 0;
    for (int s = 0; s < 3; s++) begin
      hbph[s] = 0;
      for (int k = 0; k < 7; k++) hbw[s][k] = 0;
    end
    hx1 = 0; hy1 = 0;
  endtask

  // R4: four cascaded 8-sample running sums as one 29-tap kernel
  task automatic build_kernel();
    longint a [29];
    longint b [29];
    for (int k = 0; k < 29; k++) a[k] = (k == 0) ? 1 : 0;
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 29; k++) begin
        b[k] = 0;
        for (int j = 0; j < 8; j++) if (k - j >= 0) b[k] += a[k-j];
      end
      a = b;
    end
    coef = a;
  endtask

  // feed one accepted input to the model; drive_cyc is the negedge cycle of the drive
  task automatic model_push(longint x, longint drive_cyc, bit byp);
    longint v, y, leak, raw, res;
    bit out_now;
    for (int k = 28; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = x;
    accepted++;
    if (accepted % 8 != 0) return;
    v = 0;
    for (int k = 0; k < 29; k++) v += coef[k] * hist[k];
    v = v <<< SCALE;
    for (int s = 0; s < 3; s++) begin
      for (int k = 6; k > 0; k--) hbw[s][k] = hbw[s][k-1];
      hbw[s][0] = v;
      out_now = hbph[s];
      hbph[s] = ~hbph[s];
      if (!out_now) return;
      // R5
      v = (-hbw[s][0] + 9*hbw[s][2] + 16*hbw[s][3] + 9*hbw[s][4] - hbw[s][6]) >>> 5;
    end
    // R6 / R7 / R8
    if (hy1 > 0) leak = (hy1 + (64'sd1 <<< SHIFT) - 1) >>> SHIFT;
    else         leak = hy1 >>> SHIFT;
    raw = v - hx1 + hy1 - leak;
    y   = sat(raw);
    hx1 = v; hy1 = y;
    res = byp ? sat(v) : y;
    exp_val.push_back(res);
    exp_cyc.push_back(drive_cyc + 5);   // R3
  endtask

  // output monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      outs++;
      last_out = out_sample;
      if (longint'(out_sample) == MAXV) saw_max = 1;
      if (exp_val.size() == 0) begin
        check(0, "R2 unexpected strobe", 1, 0);
      end else begin
        longint ev, ec;
        ev = exp_val.pop_front();
        ec = exp_cyc.pop_front();
        check(longint'(out_sample) == ev, "R4/R5/R6 value", out_sample, ev);
        check(cyc == ec, "R3 arrival cycle", cyc, ec);
      end
    end
  end

  task automatic drive(bit v, longint x);
    @(negedge clk);
    in_valid  = v;
    in_sample = IN_W'(x);
    if (v) model_push(x, cyc, hp_bypass);
  endtask

  task automatic drain();
    for (int k = 0; k < 20; k++) drive(0, 0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240517));
    build_kernel();
    model_reset();
    saw_max = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_sample = '0; hp_bypass = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
    check(out_sample == '0, "R1 data in reset", out_sample, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R1 valid after release", out_valid, 0);
    check(out_sample == '0, "R1 data after release", out_sample, 0);

    // random stream with gaps, high-pass active (R2, R4, R5, R6)
    for (int n = 0; n < 64*100; ) begin
      bit v;
      v = ($urandom % 4) != 0;
      drive(v, longint'($urandom % 16) - 8);
      if (v) n++;
    end
    drain();
    check(outs == accepted / 64, "R2 result count", outs, accepted / 64);
    // R2: idle stretch changes nothing
    begin
      longint held;
      held = out_sample;
      for (int k = 0; k < 100; k++) drive(0, 7);
      check(longint'(out_sample) == held, "R2 idle hold", out_sample, held);
    end

    // random stream in bypass (R8)
    hp_bypass = 1'b1;
    for (int n = 0; n < 64*60; ) begin
      bit v;
      v = ($urandom % 3) != 0;
      drive(v, longint'($urandom % 16) - 8);
      if (v) n++;
    end
    drain();

    // R9: DC 3 with high-pass active settles to 0
    hp_bypass = 1'b0;
    for (int n = 0; n < 64*400; n++) drive(1, 3);
    drain();
    check(last_out == 0, "R9 DC removed", last_out, 0);

    // R7: settle at -8 then step to +7 must clip to the top rail
    for (int n = 0; n < 64*400; n++) drive(1, -8);
    saw_max = 0;
    for (int n = 0; n < 64*12; n++) drive(1, 7);
    drain();
    check(saw_max, "R7 clipped to max", saw_max, 1);

    // R9: bypass passes DC at unity
    hp_bypass = 1'b1;
    for (int n = 0; n < 64*10; n++) drive(1, -8);
    drain();
    check(last_out == -(64'sd8 <<< (OUT_W - IN_W)), "R9 bypass DC -8", last_out,
          -(64'sd8 <<< (OUT_W - IN_W)));
    for (int n = 0; n < 64*10; n++) drive(1, 7);
    drain();
    check(last_out == (64'sd7 <<< (OUT_W - IN_W)), "R9 bypass DC +7", last_out,
          64'sd7 <<< (OUT_W - IN_W));

    check(outs == accepted / 64, "R2 final count", outs, accepted / 64);
    check(exp_val.size() == 0, "R2 nothing pending", exp_val.size(), 0);
    summary();
    $finish;
  end
endmodule